// File: doc/BRIEF.md
# External trigger pin condition detector

This block watches a pair of external trigger inputs and raises a trigger flag for each pin when any of that pin's enabled conditions holds. Each pin has five conditions that can be enabled: low level, high level, any edge, rising edge and falling edge. Any combination may be enabled at the same time, and the pin's flag is the OR of every enabled condition.

All five enables for both pins come from one configuration word, interleaved by pin. The bit index is `condition * 2 + pin`, with the condition order low=0, high=1, any=2, rise=3 and fall=4.

The pin inputs are asynchronous. Each passes through a two-flop synchroniser into the sampling clock domain. Edges are found by comparing the synchronised level with a registered copy from the previous cycle. The flags are registered outputs. A consumer samples them on the same clock and treats each high cycle as one trigger event.

The reset input is asserted asynchronously. Its release is expected to be already aligned to the clock.

Top module: `trig_pin_detect`

## Requirements
- R1: While `rst_ni` is low, `trig_o` is 2'b00 whatever the pins and configuration are.
- R2: Pin 0 uses the even configuration bits: low level bit 0, high level bit 2, any edge bit 4, rising edge bit 6, falling edge bit 8. `trig_o[0]` reports it.
- R3: Pin 1 uses the odd configuration bits: low level bit 1, high level bit 3, any edge bit 5, rising edge bit 7, falling edge bit 9. `trig_o[1]` reports it.
- R4: With a level condition enabled, the flag stays high on every cycle that the synchronised pin matches that level.
- R5: A rising-edge or falling-edge condition raises the flag for exactly one cycle per matching transition.
- R6: The any-edge condition fires once for each transition in either direction. A one-cycle pulse on a pin gives two flag cycles, back to back.
- R7: When several conditions are enabled for a pin, its flag is the OR of those conditions in the same cycle.
- R8: A disabled condition has no effect. Activity on one pin never raises the other pin's flag. With the configuration word at zero, both flags stay low.
- R9: A pin change shows on the flag after the third rising clock edge that follows it: two synchroniser stages plus the output register. A configuration change takes effect at the next rising edge.
- R10: After reset is released, no edge is reported for the pin's starting value, even when the pin is already high. Level conditions still report that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_i | input | 2 | External trigger pins, asynchronous to `clk_i` |
| cfg_i | input | 10 | Condition enables, bit index = condition*2 + pin |
| trig_o | output | 2 | Per-pin registered trigger flag |

## Verification
The hardest case to reach from the ports is a pin that is already high when reset is released. The previous-value register must be loaded from the first synchronised sample, and no edge may be counted from the reset value of the synchroniser. The stimulus holds both pins high and enables both edge conditions, then asserts and releases reset. It checks that no flag rises for several cycles, and then that a high-level enable does report the pin.

A one-cycle pin pulse with the any-edge condition enabled exercises two transitions in consecutive cycles. It checks that exactly two flag cycles result.

// File: rtl/trig_pin_pkg.sv
package trig_pin_pkg;

  // Condition indices; configuration bit = index * NUM_PINS + pin
  localparam int unsigned COND_LOW  = 0;
  localparam int unsigned COND_HIGH = 1;
  localparam int unsigned COND_ANY  = 2;
  localparam int unsigned COND_RISE = 3;
  localparam int unsigned COND_FALL = 4;
  localparam int unsigned NUM_COND  = 5;

  typedef logic [NUM_COND-1:0] cond_vec_t;

endpackage

// File: rtl/trig_pin_sync.sv
module trig_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic vld_o
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic [STAGES-1:0] vq_q, vq_d;

  // vq tracks how far real samples have travelled through the chain
  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin_i};
    vq_d = {vq_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      vq_q <= '0;
    end else begin
      sh_q <= sh_d;
      vq_q <= vq_d;
    end
  end

  assign lvl_o = sh_q[STAGES-1];
  assign vld_o = vq_q[STAGES-1];

endmodule

// File: rtl/trig_pin_cond.sv
module trig_pin_cond
  import trig_pin_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  logic      vld_i,
  input  cond_vec_t en_i,
  output logic      hit_o
);

  logic      prev_q, prev_d, prev_en;
  logic      pvld_q, pvld_d;
  logic      edge_ok;
  cond_vec_t cond;

  // previous-value register loads only real samples
  assign prev_en = vld_i;

  always_comb begin
    prev_d = prev_en ? lvl_i : prev_q;
    pvld_d = pvld_q | vld_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pvld_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pvld_q <= pvld_d;
    end
  end

  always_comb begin
    edge_ok         = vld_i & pvld_q;
    cond            = '0;
    cond[COND_LOW]  = vld_i & ~lvl_i;
    cond[COND_HIGH] = vld_i & lvl_i;
    cond[COND_ANY]  = edge_ok & (lvl_i ^ prev_q);
    cond[COND_RISE] = edge_ok & lvl_i & ~prev_q;
    cond[COND_FALL] = edge_ok & ~lvl_i & prev_q;
    hit_o           = |(cond & en_i);
  end

  // R5: an edge condition never holds two cycles running
  a_r5_rise_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond[COND_RISE] |=> !cond[COND_RISE]);
  a_r5_fall_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond[COND_FALL] |=> !cond[COND_FALL]);
  // R6: a repeat of any-edge needs a fresh level change
  a_r6_any_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond[COND_ANY] |=> (!cond[COND_ANY] || !$stable(lvl_i)));

endmodule

// File: rtl/trig_pin_detect.sv
module trig_pin_detect
  import trig_pin_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CFG_W      = NUM_COND * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [CFG_W-1:0]    cfg_i,
  output logic [NUM_PINS-1:0] trig_o
);

  logic [NUM_PINS-1:0] lvl, vld, hit;
  logic [NUM_PINS-1:0] trig_q, trig_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    cond_vec_t en;

    // interleaved decode: one enable per condition for this pin
    for (genvar c = 0; c < NUM_COND; c++) begin : g_en
      assign en[c] = cfg_i[c*NUM_PINS + p];
    end

    trig_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i[p]),
      .lvl_o (lvl[p]),
      .vld_o (vld[p])
    );

    trig_pin_cond u_cond (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl[p]),
      .vld_i (vld[p]),
      .en_i  (en),
      .hit_o (hit[p])
    );

    // R4: enabled level seen by the synchroniser reaches the flag
    a_r4_high_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld[p] && lvl[p] && cfg_i[COND_HIGH*NUM_PINS + p]) |=> trig_o[p]);
    a_r4_low_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld[p] && !lvl[p] && cfg_i[COND_LOW*NUM_PINS + p]) |=> trig_o[p]);
  end

  always_comb trig_d = hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= trig_d;
  end

  assign trig_o = trig_q;

  // R8: nothing enabled, nothing reported
  a_r8_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == '0) |=> (trig_o == '0));

endmodule

// File: tb/trig_pin_detect_bench.sv
module trig_pin_detect_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pins;
  logic [9:0] cfg;
  logic [1:0] trig;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  trig_pin_detect u_trig_pin_detect (
    .clk_i (clk),
    .rst_ni(rst_n),
    .pin_i (pins),
    .cfg_i (cfg),
    .trig_o(trig)
  );

  // row = {cfg[9:0], pins[1:0], expected flags[1:0]}; each row held 3 edges
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {10'h001, 2'b00, 2'b01},  // R2 pin0 low
    {10'h004, 2'b01, 2'b01},  // R2 pin0 high
    {10'h040, 2'b00, 2'b00},  // R2 rise enabled, falling edge seen
    {10'h040, 2'b01, 2'b01},  // R2 pin0 rise
    {10'h100, 2'b00, 2'b01},  // R2 pin0 fall
    {10'h010, 2'b01, 2'b01},  // R6 any, rising
    {10'h010, 2'b00, 2'b01},  // R6 any, falling
    {10'h010, 2'b00, 2'b00},  // R6 any, no change
    {10'h002, 2'b00, 2'b10},  // R3 pin1 low
    {10'h008, 2'b10, 2'b10},  // R3 pin1 high
    {10'h080, 2'b00, 2'b00},  // R3 rise enabled, falling edge seen
    {10'h080, 2'b10, 2'b10},  // R3 pin1 rise
    {10'h200, 2'b00, 2'b10},  // R3 pin1 fall
    {10'h020, 2'b10, 2'b10},  // R3 any, rising
    {10'h020, 2'b00, 2'b10},  // R3 any, falling
    {10'h040, 2'b10, 2'b00},  // R8 pin1 edge leaves pin0 flag low
    {10'h3FF, 2'b11, 2'b11},  // R7 all enabled
    {10'h0C0, 2'b11, 2'b00},  // R5 rise, no new edge
    {10'h000, 2'b00, 2'b00},  // R8 nothing enabled
    {10'h014, 2'b01, 2'b01},  // R7 high or any
    {10'h014, 2'b01, 2'b01}   // R7 high persists
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: trig=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int cnt;
    rst_n = 1'b0;
    pins  = 2'b11;
    cfg   = 10'h3FF;
    repeat (3) @(negedge clk);
    chk("R1", trig, 2'b00);
    pins = 2'b00;
    repeat (2) @(negedge clk);
    chk("R1", trig, 2'b00);
    rst_n = 1'b1;
    cfg   = 10'h000;
    repeat (4) @(negedge clk);
    chk("R8", trig, 2'b00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      cfg  = VEC[i][13:4];
      pins = VEC[i][3:2];
      repeat (3) @(negedge clk);
      chk($sformatf("R2/R3 row %0d", i), trig, VEC[i][1:0]);
    end

    // R5 / R9: latency and one-cycle rising edge
    cfg  = 10'h040;
    pins = 2'b00;
    repeat (4) @(negedge clk);
    pins = 2'b01;
    repeat (2) @(negedge clk);
    chk("R9 before third edge", trig, 2'b00);
    @(negedge clk);
    chk("R9 third edge", trig, 2'b01);
    @(negedge clk);
    chk("R5 one cycle", trig, 2'b00);

    // R4: level every cycle
    cfg  = 10'h008;
    pins = 2'b10;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R4 level held", trig, 2'b10);
      @(negedge clk);
    end

    // R6: one-cycle pulse gives two flag cycles
    cfg  = 10'h010;
    pins = 2'b00;
    repeat (4) @(negedge clk);
    pins = 2'b01;
    @(negedge clk);
    pins = 2'b00;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (trig[0]) cnt++;
    end
    chk("R6 pulse count", cnt[1:0], 2'd2);

    // R10: pins high through reset, no false edge
    cfg   = 10'h3C0;
    pins  = 2'b11;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", trig, 2'b00);
    rst_n = 1'b1;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (trig != 2'b00) cnt++;
    end
    chk("R10 no edge after reset", cnt[1:0], 2'd0);
    cfg = 10'h00C;
    @(negedge clk);
    chk("R10/R9 level after reset", trig, 2'b11);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: trig=%b expected=done", trig);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule